// File: doc/BRIEF.md
# Subcarrier Tag Response Encoder

This block turns one tag response into the on/off control for a load modulator. A response word, a keystream word and a bit count arrive together as one transfer on a valid/ready input. The encoder keeps the low `n` bits of the response XORed with the matching keystream bits, with `n` taken from the bit count. It then plays out a frame of chips. The frame is a fixed 8-chip start pattern, then two chips for every payload bit, then a fixed 8-chip end pattern.

A chip lasts `2*SC_HALF*SC_PULSES` clock cycles, where the clock runs at the carrier frequency. A "1" chip is `SC_PULSES` subcarrier pulses, each high for `SC_HALF` cycles and then low for `SC_HALF` cycles. A "0" chip keeps the output low for the whole chip. The defaults give 8 pulses at carrier/64, so one chip is 512 carrier cycles.

Typical payloads are 6 bits for a handshake reply and 12 bits for a read reply (8 data bits with a 4-bit check value above them). The keystream and the check value are produced outside the block.

The input holds back by keeping `start_ready` low for the whole frame. A transfer is taken only in a cycle where `start_valid` and `start_ready` are both high. While a frame is running, `start_valid` and the payload inputs are ignored. The source may keep them asserted, and the transfer is then taken once the frame has ended.

Top module: `subcarrier_resp_enc`

## Requirements
- R1: `start_ready` is high exactly when the encoder is idle. A transfer is taken when `start_valid` and `start_ready` are both high at a rising edge. `busy` is high from the next cycle on.
- R2: While `busy` is high, `start_valid` and the payload inputs have no effect. The running frame's chip stream is unchanged, and no second frame begins unless a transfer is taken after `done`.
- R3: A "1" chip is `SC_PULSES` pulses, each `SC_HALF` cycles high then `SC_HALF` cycles low, starting high. A "0" chip is low for all `2*SC_HALF*SC_PULSES` cycles.
- R4: The frame opens with the chip sequence 0,0,0,1,1,1,0,1.
- R5: Payload bits are sent least significant bit first. A 1 is sent as chip 0 then chip 1, and a 0 as chip 1 then chip 0.
- R6: The bit sent at position k is `start_data[k] XOR start_key[k]`. Bits at positions k >= n have no effect.
- R7: After the last payload bit, the frame closes with the chip sequence 1,0,1,1,1,0,0,0.
- R8: A bit count of 0, or any count above `MAX_BITS`, is treated as `MAX_BITS`.
- R9: `busy` stays high for exactly `(16+2n)` chip periods. `done` is high for exactly one cycle, the first cycle after the last chip, and `busy` is low in that cycle.
- R10: During and after reset, `mod_out`, `busy` and `done` are low and `start_ready` is high.
- R11: `mod_out` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | A response transfer is offered |
| start_ready | output | 1 | The encoder is idle and will take a transfer |
| start_data | input | MAX_BITS | Response bits, bit 0 sent first |
| start_key | input | MAX_BITS | Keystream bits XORed into the response |
| start_len | input | LEN_W | Number of payload bits; 0 or above MAX_BITS means MAX_BITS |
| mod_out | output | 1 | Modulation enable |
| busy | output | 1 | A frame is being sent |
| done | output | 1 | One-cycle pulse after the final chip |

## Verification
Take the accept edge as time zero and call the chip length CL. Cycle j of chip i is due in the cycle that starts i*CL+j edges later. `busy` rises and `start_ready` falls one edge after acceptance. `done` is due (16+2n)*CL edges after acceptance, and it must fall again one edge after that. The bench drives inputs and samples outputs on the falling clock edge. It walks a cycle counter from the accept edge and compares every cycle of the frame against a waveform it computes from the chip index and the offset within the chip. It then checks the `done` cycle and the cycle after it at their exact positions.

// File: rtl/sre_pkg.sv
package sre_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SOF  = 2'd1,
    PH_DATA = 2'd2,
    PH_EOF  = 2'd3
  } sre_phase_e;

  // Framing chip patterns, transmitted from bit 7 downwards
  localparam logic [7:0] SOF_CHIPS = 8'h1D;
  localparam logic [7:0] EOF_CHIPS = 8'hB8;
  localparam int unsigned FRAME_CHIPS = 8;
endpackage

// File: rtl/sre_chip_timer.sv
module sre_chip_timer #(
  parameter int unsigned SC_HALF   = 32,
  parameter int unsigned SC_PULSES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sc_hi,
  output logic chip_end
);
  localparam int unsigned SUB_N = 2 * SC_HALF;
  localparam int unsigned SUB_W = (SUB_N > 1) ? $clog2(SUB_N) : 1;
  localparam int unsigned PUL_W = (SC_PULSES > 1) ? $clog2(SC_PULSES) : 1;

  logic [SUB_W-1:0] sub_cnt;
  logic [PUL_W-1:0] pulse_cnt;
  logic sub_last, pulse_last;

  assign sub_last   = (sub_cnt == SUB_W'(SUB_N - 1));
  assign pulse_last = (pulse_cnt == PUL_W'(SC_PULSES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      sub_cnt   <= '0;
      pulse_cnt <= '0;
    end else if (sub_last) begin
      sub_cnt   <= '0;
      pulse_cnt <= pulse_last ? '0 : pulse_cnt + 1'b1;
    end else begin
      sub_cnt <= sub_cnt + 1'b1;
    end
  end

  assign sc_hi    = (sub_cnt < SUB_W'(SC_HALF));
  assign chip_end = run && sub_last && pulse_last;
endmodule

// File: rtl/sre_frame_seq.sv
module sre_frame_seq
  import sre_pkg::*;
#(
  parameter int unsigned MAX_BITS = 16,
  localparam int unsigned LEN_W   = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic [MAX_BITS-1:0] in_data,
  input  logic [MAX_BITS-1:0] in_key,
  input  logic [LEN_W-1:0]    in_len,
  input  logic                chip_end,
  output logic                busy,
  output logic                chip_bit,
  output logic                done
);
  sre_phase_e          phase;
  logic [7:0]          pat_sh;
  logic [2:0]          pat_cnt;
  logic [MAX_BITS-1:0] pay_sh;
  logic [LEN_W-1:0]    bits_left;
  logic                second_chip;

  logic [LEN_W-1:0]    n_eff;
  logic [MAX_BITS-1:0] keep_mask;

  assign n_eff = ((in_len == '0) || (in_len > LEN_W'(MAX_BITS))) ? LEN_W'(MAX_BITS) : in_len;

  always_comb begin
    for (int k = 0; k < int'(MAX_BITS); k++)
      keep_mask[k] = (k < int'(n_eff));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      pat_sh      <= '0;
      pat_cnt     <= '0;
      pay_sh      <= '0;
      bits_left   <= '0;
      second_chip <= 1'b0;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        phase       <= PH_SOF;
        pat_sh      <= SOF_CHIPS;
        pat_cnt     <= '0;
        pay_sh      <= (in_data ^ in_key) & keep_mask;
        bits_left   <= n_eff;
        second_chip <= 1'b0;
      end else if (chip_end) begin
        unique case (phase)
          PH_SOF: begin
            pat_sh <= pat_sh << 1;
            if (pat_cnt == 3'd7) begin
              phase       <= PH_DATA;
              second_chip <= 1'b0;
            end else begin
              pat_cnt <= pat_cnt + 1'b1;
            end
          end
          PH_DATA: begin
            if (!second_chip) begin
              second_chip <= 1'b1;
            end else begin
              second_chip <= 1'b0;
              pay_sh      <= pay_sh >> 1;
              bits_left   <= bits_left - 1'b1;
              if (bits_left == LEN_W'(1)) begin
                phase   <= PH_EOF;
                pat_sh  <= EOF_CHIPS;
                pat_cnt <= '0;
              end
            end
          end
          PH_EOF: begin
            pat_sh <= pat_sh << 1;
            if (pat_cnt == 3'd7) begin
              phase <= PH_IDLE;
              done  <= 1'b1;
            end else begin
              pat_cnt <= pat_cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (phase)
      PH_SOF, PH_EOF: chip_bit = pat_sh[7];
      PH_DATA:        chip_bit = second_chip ? pay_sh[0] : ~pay_sh[0];
      default:        chip_bit = 1'b0;
    endcase
  end

  assign busy = (phase != PH_IDLE);
endmodule

// File: rtl/subcarrier_resp_enc.sv
module subcarrier_resp_enc #(
  parameter int unsigned SC_HALF   = 32,
  parameter int unsigned SC_PULSES = 8,
  parameter int unsigned MAX_BITS  = 16,
  localparam int unsigned LEN_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_valid,
  output logic                start_ready,
  input  logic [MAX_BITS-1:0] start_data,
  input  logic [MAX_BITS-1:0] start_key,
  input  logic [LEN_W-1:0]    start_len,
  output logic                mod_out,
  output logic                busy,
  output logic                done
);
  logic accept, sc_hi, chip_end, chip_bit;

  assign start_ready = ~busy;
  assign accept      = start_valid & start_ready;

  sre_chip_timer #(
    .SC_HALF  (SC_HALF),
    .SC_PULSES(SC_PULSES)
  ) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .sc_hi   (sc_hi),
    .chip_end(chip_end)
  );

  sre_frame_seq #(
    .MAX_BITS(MAX_BITS)
  ) seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .in_data (start_data),
    .in_key  (start_key),
    .in_len  (start_len),
    .chip_end(chip_end),
    .busy    (busy),
    .chip_bit(chip_bit),
    .done    (done)
  );

  assign mod_out = busy & chip_bit & sc_hi;
endmodule

// File: rtl/sre_checker.sv
module sre_checker (
  input logic clk,
  input logic rst_n,
  input logic start_valid,
  input logic start_ready,
  input logic mod_out,
  input logic busy,
  input logic done
);
  // R1: a taken transfer starts a frame on the next cycle
  a_r1_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready) |=> busy);

  // R1 R2: a frame only ever begins from a taken transfer
  a_r2_rise_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_valid && start_ready));

  // R9: done follows the end of a frame
  a_r9_done_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R9: done lasts a single cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: no modulation while idle
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mod_out);
endmodule

bind subcarrier_resp_enc sre_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_valid(start_valid),
  .start_ready(start_ready),
  .mod_out    (mod_out),
  .busy       (busy),
  .done       (done)
);

// File: tb/subcarrier_resp_enc_tb_top.sv
module subcarrier_resp_enc_tb_top;
  localparam int H  = 2;
  localparam int P  = 2;
  localparam int MB = 16;
  localparam int LW = $clog2(MB + 1);
  localparam int CL = 2 * H * P;
  localparam logic [7:0] SOF = 8'b0001_1101;
  localparam logic [7:0] EOF = 8'b1011_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_valid = 1'b0;
  logic start_ready;
  logic [MB-1:0] start_data = '0;
  logic [MB-1:0] start_key = '0;
  logic [LW-1:0] start_len = '0;
  logic mod_out, busy, done;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  subcarrier_resp_enc #(.SC_HALF(H), .SC_PULSES(P), .MAX_BITS(MB)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .start_data(start_data), .start_key(start_key), .start_len(start_len),
    .mod_out(mod_out), .busy(busy), .done(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_chip(input int i, input int n, input logic [MB-1:0] w);
    int j, e;
    if (i < 8) return SOF[7-i];
    j = i - 8;
    if (j < 2 * n) return (j % 2 == 1) ? w[j/2] : ~w[j/2];
    e = j - 2 * n;
    return EOF[7-e];
  endfunction

  task automatic run_frame(input logic [MB-1:0] d, input logic [MB-1:0] k,
                           input int len, input bit poke, input string tag);
    int n, total, e_sof, e_dat, e_eof, e_ctl, highs3;
    logic [MB-1:0] w;
    n = (len == 0 || len > MB) ? MB : len;
    w = d ^ k;
    total = 16 + 2 * n;
    e_sof = 0; e_dat = 0; e_eof = 0; e_ctl = 0; highs3 = 0;
    @(negedge clk);
    chk(start_ready === 1'b1, "R1 ready when idle", int'(start_ready), 1);
    start_valid = 1'b1;
    start_data = d;
    start_key = k;
    start_len = LW'(len);
    @(negedge clk);
    if (poke) begin
      start_data = ~d;
      start_key = d;
      start_len = LW'(3);
    end else begin
      start_valid = 1'b0;
    end
    for (int t = 0; t < total * CL; t++) begin
      int ci, wi;
      bit e;
      ci = t / CL;
      wi = t % CL;
      e = exp_chip(ci, n, w) && ((wi % (2 * H)) < H);
      if (mod_out !== e) begin
        if (ci < 8) e_sof++;
        else if (ci < 8 + 2 * n) e_dat++;
        else e_eof++;
      end
      if (busy !== 1'b1 || start_ready !== 1'b0 || done !== 1'b0) e_ctl++;
      if (ci == 3 && mod_out === 1'b1) highs3++;
      if (poke && t == total * CL - 1) start_valid = 1'b0;
      @(negedge clk);
    end
    chk(e_sof == 0, {"R4 start pattern ", tag}, e_sof, 0);
    chk(e_dat == 0, {"R5 R6 payload chips ", tag}, e_dat, 0);
    chk(e_eof == 0, {"R7 end pattern ", tag}, e_eof, 0);
    chk(highs3 == P * H, "R3 high cycles in a one chip", highs3, P * H);
    chk(e_ctl == 0, {"R9 busy for whole frame ", tag}, e_ctl, 0);
    chk(done === 1'b1 && busy === 1'b0, {"R9 done after last chip ", tag}, int'(done), 1);
    chk(start_ready === 1'b1, "R1 ready in done cycle", int'(start_ready), 1);
    @(negedge clk);
    chk(done === 1'b0, "R9 done single cycle", int'(done), 0);
    if (poke) begin
      int extra;
      extra = 0;
      for (int q = 0; q < 3; q++) begin
        if (busy !== 1'b0 || mod_out !== 1'b0) extra++;
        @(negedge clk);
      end
      chk(extra == 0, "R2 no frame from ignored transfer", extra, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(mod_out === 1'b0 && busy === 1'b0 && done === 1'b0, "R10 outputs in reset",
        int'({mod_out, busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(start_ready === 1'b1 && busy === 1'b0, "R10 idle after reset", int'(start_ready), 1);
    chk(mod_out === 1'b0, "R11 quiet while idle", int'(mod_out), 0);

    // R6: every 6-bit handshake reply, whitened by a varying key
    for (int v = 0; v < 64; v++)
      run_frame(MB'(v) | 16'hC0C0, MB'(v * 41) ^ 16'hA5C3, 6, 1'b0, "R6 handshake");

    // R8: every bit count, including out-of-range ones
    for (int l = 0; l < 32; l += ((l < 20) ? 1 : 11)) begin
      string tg;
      tg = (l == 0 || l > MB) ? "R8 clamped" : "length sweep";
      run_frame(16'hFFFF, 16'h0000, l, 1'b0, tg);
      run_frame(16'h0000, 16'h0000, l, 1'b0, tg);
      run_frame(16'hB3E1, 16'h5A0F, l, 1'b0, tg);
    end

    // R2: read replies with the source pressing during the frame
    run_frame(16'h0A5C, 16'h0F33, 12, 1'b1, "R2 pressed");
    run_frame(16'h0FFF, 16'h0123, 12, 1'b1, "R2 pressed");
    run_frame(16'h0001, 16'h0000, 1, 1'b1, "R2 pressed");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule